// File: doc/BRIEF.md
# Picture-in-Picture Sub-Picture Decimation Writer

This block takes the digitised sub-picture stream (8-bit luma plus 8-bit blue and red colour-difference samples, one pixel per `pix_valid` cycle) together with line and field start pulses. It shrinks the picture by 3:1 or 4:1 on each axis, which gives a one-ninth or a one-sixteenth inset. It then issues write strobes, addresses and 6-bit data to the single-field sub-picture store. Luma is averaged vertically over the input lines that merge into one stored line. Colour difference is kept at one pair per six stored luma samples. The count of stored luma samples runs across line boundaries, so with 171 samples per line the pairs alternate between 29 and 28 per line.

The store is organised as a luma bank with one 6-bit word per stored sample and a chroma bank with one 12-bit word per colour pair. In one-ninth mode a field needs 11799 luma words and 1967 pair words, about 94.4 kbit, which fits a 96 kbit macro. A freeze input suppresses every write, so the stored picture stays on screen while the counting carries on.

Top module: `pip_decim_writer`

## Requirements
- R1: After reset, `y_we`, `c_we` and `field_done` are low.
- R2: `size_sel` is captured on the `field_start` cycle: 0 selects 3:1 per axis with NL9 (69) stored lines, and 1 selects 4:1 per axis with NL16 (52) stored lines. Later changes of `size_sel` within the field have no effect.
- R3: Counting from each `line_start`, the first pixel of every group of F input pixels is kept (F = 3 or 4), up to NCOL (171) kept pixels per line. Later pixels of the line are dropped, and so is a pixel on the `line_start` cycle.
- R4: Stored luma for output line L and column c is the mean of luma at pixel F*c of input lines F*L to F*L+F-1, rounded as (sum+F/2)/F, then reduced to 6 bits as min(63,(v+2)>>2).
- R5: Luma writes go to address L*NCOL+c in increasing order. They occur during the last input line of each group, one cycle after the kept pixel.
- R6: A chroma write happens together with each luma write whose address is a multiple of 6. It uses `c_addr` = `y_addr`/6 and `c_data` = {red[5:0], blue[5:0]}, taken from the kept pixel on the group's last line and quantised as in R4.
- R7: Input lines after the last stored line, and pixels before the first `line_start` of a field, produce no writes.
- R8: A pixel sampled while `freeze` is high produces no luma or chroma write, and the addressing still advances.
- R9: `field_done` is high for one cycle, together with the write slot of the last luma sample of the field (address NCOL*NL-1), and it pulses even when frozen.
- R10: `field_start` restarts line counting and addressing at 0, even in the middle of a field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_start | input | 1 | One-cycle pulse at the start of a field |
| line_start | input | 1 | One-cycle pulse before the first pixel of a line |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_y | input | 8 | Luma sample |
| pix_cb | input | 8 | Blue colour-difference sample, offset binary |
| pix_cr | input | 8 | Red colour-difference sample, offset binary |
| size_sel | input | 1 | 0 = one-ninth, 1 = one-sixteenth |
| freeze | input | 1 | Suppress all writes |
| y_we | output | 1 | Luma write strobe |
| y_addr | output | YA_W (14) | Luma word address |
| y_data | output | 6 | Luma word |
| c_we | output | 1 | Chroma pair write strobe |
| c_addr | output | CA_W (11) | Chroma pair address |
| c_data | output | 12 | {red, blue} 6-bit pair |
| field_done | output | 1 | Last line of the field stored |

## Verification
A corrupted vertical accumulator shows up as a wrong `y_data` value on the next output line, at most F input lines later. A slipped pixel or line phase moves the sampling point and spoils the data from the first affected write. A line counter or size latch that is out of step changes the order of addresses or the total number of writes, which the bench sees at the end of each field. Misaligned chroma shows at once as a `c_addr` that is not `y_addr`/6, or as a wrong pair value.

// File: rtl/pip_dec_pkg.sv
package pip_dec_pkg;
    localparam int PIX_W = 8;
    localparam int Q_W   = 6;
    localparam int SUM_W = PIX_W + 2;
    localparam int SHIFT = PIX_W - Q_W;
    localparam int PW1   = PIX_W + 1;
    localparam int SW1   = SUM_W + 1;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [Q_W-1:0]   q_t;
    typedef logic [SUM_W-1:0] sum_t;

    typedef enum logic {
        SZ_NINTH     = 1'b0,
        SZ_SIXTEENTH = 1'b1
    } pip_size_e;

    typedef struct packed {
        q_t cr;
        q_t cb;
    } cpair_t;

    function automatic logic [2:0] decim_factor(pip_size_e s);
        return (s == SZ_SIXTEENTH) ? 3'd4 : 3'd3;
    endfunction

    // Round to Q_W bits with saturation at the top code.
    function automatic q_t quantise(pix_t v);
        logic [PIX_W:0] t;
        t = ({1'b0, v} + PW1'(1 << (SHIFT - 1))) >> SHIFT;
        if (t > PW1'((1 << Q_W) - 1)) return '1;
        return q_t'(t);
    endfunction

    // Rounded mean of f summed samples.
    function automatic pix_t vavg(sum_t s, logic [2:0] f);
        logic [SUM_W:0] t;
        t = ({1'b0, s} + SW1'(f >> 1)) / SW1'(f);
        return pix_t'(t);
    endfunction
endpackage

// File: rtl/pip_hcount.sv
module pip_hcount
    import pip_dec_pkg::*;
#(
    parameter int NCOL = 171,
    localparam int COL_W = $clog2(NCOL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             pix_valid,
    input  logic [2:0]       factor,
    output logic [COL_W-1:0] col,
    output logic             keep
);
    logic [1:0] ph;

    assign keep = pix_valid && !clr && (ph == 2'd0) && (col < COL_W'(NCOL));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ph  <= 2'd0;
            col <= '0;
        end else if (pix_valid) begin
            ph <= ({1'b0, ph} == factor - 3'd1) ? 2'd0 : ph + 2'd1;
            if (keep) col <= col + 1'b1;
        end
    end

    assert_col_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(col) <= NCOL);
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !clr) |=> $stable(col));
endmodule

// File: rtl/pip_vfilter.sv
module pip_vfilter
    import pip_dec_pkg::*;
#(
    parameter int NCOL = 171,
    localparam int COL_W = $clog2(NCOL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_en,
    input  logic             first,
    input  logic [COL_W-1:0] col,
    input  pix_t             pix,
    input  logic [2:0]       factor,
    output q_t               yq
);
    sum_t acc [NCOL];
    sum_t prev;
    sum_t sum;

    always_comb begin
        prev = (int'(col) < NCOL) ? acc[col] : '0;
        sum  = first ? sum_t'(pix) : prev + sum_t'(pix);
        yq   = quantise(vavg(sum, factor));
    end

    always_ff @(posedge clk) begin
        if (acc_en) acc[col] <= sum;
    end

    assert_acc_index_R4: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> int'(col) < NCOL);
endmodule

// File: rtl/pip_linectl.sv
module pip_linectl
    import pip_dec_pkg::*;
#(
    parameter int NCOL = 171,
    parameter int NL9  = 69,
    parameter int NL16 = 52,
    parameter int CDIV = 6,
    localparam int COL_W  = $clog2(NCOL + 1),
    localparam int LN_MAX = (NL9 > NL16) ? NL9 : NL16,
    localparam int LN_W   = $clog2(LN_MAX + 1),
    localparam int YA_W   = $clog2(NCOL * LN_MAX),
    localparam int CA_W   = $clog2((NCOL * LN_MAX + CDIV - 1) / CDIV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             field_start,
    input  logic             line_start,
    input  pip_size_e        size,
    input  logic             keep,
    input  logic [COL_W-1:0] col,
    output logic             acc_en,
    output logic             group_first,
    output logic             emit,
    output logic             done_evt,
    output logic [YA_W-1:0]  y_addr,
    output logic             c_hit,
    output logic [CA_W-1:0]  c_addr
);
    logic            started;
    logic [1:0]      lph;
    logic [LN_W-1:0] oline;
    logic [LN_W-1:0] nl;
    logic [2:0]      factor;
    logic            line_ok;
    logic            group_last;

    assign factor     = decim_factor(size);
    assign nl         = (size == SZ_SIXTEENTH) ? LN_W'(NL16) : LN_W'(NL9);
    assign line_ok    = started && (oline < nl);
    assign group_first = (lph == 2'd0);
    assign group_last = ({1'b0, lph} == factor - 3'd1);
    assign acc_en     = keep && line_ok;
    assign emit       = acc_en && group_last;
    assign done_evt   = emit && (oline == nl - 1'b1) && (col == COL_W'(NCOL - 1));
    assign y_addr     = YA_W'(oline) * YA_W'(NCOL) + YA_W'(col);
    assign c_hit      = (y_addr % YA_W'(CDIV)) == '0;
    assign c_addr     = CA_W'(y_addr / YA_W'(CDIV));

    always_ff @(posedge clk) begin
        if (rst || field_start) begin
            started <= 1'b0;
            lph     <= 2'd0;
            oline   <= '0;
        end else if (line_start) begin
            if (!started) begin
                started <= 1'b1;
                lph     <= 2'd0;
            end else if (group_last) begin
                lph <= 2'd0;
                if (oline < nl) oline <= oline + 1'b1;
            end else begin
                lph <= lph + 2'd1;
            end
        end
    end

    assert_oline_bound_R7: assert property (@(posedge clk) disable iff (rst)
        oline <= nl);
    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        {1'b0, lph} < factor);
endmodule

// File: rtl/pip_decim_writer.sv
module pip_decim_writer
    import pip_dec_pkg::*;
#(
    parameter int NCOL = 171,
    parameter int NL9  = 69,
    parameter int NL16 = 52,
    parameter int CDIV = 6,
    localparam int COL_W  = $clog2(NCOL + 1),
    localparam int LN_MAX = (NL9 > NL16) ? NL9 : NL16,
    localparam int YA_W   = $clog2(NCOL * LN_MAX),
    localparam int CA_W   = $clog2((NCOL * LN_MAX + CDIV - 1) / CDIV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             field_start,
    input  logic             line_start,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_y,
    input  logic [PIX_W-1:0] pix_cb,
    input  logic [PIX_W-1:0] pix_cr,
    input  logic             size_sel,
    input  logic             freeze,
    output logic             y_we,
    output logic [YA_W-1:0]  y_addr,
    output logic [Q_W-1:0]   y_data,
    output logic             c_we,
    output logic [CA_W-1:0]  c_addr,
    output logic [2*Q_W-1:0] c_data,
    output logic             field_done
);
    pip_size_e        size_q;
    logic [2:0]       factor;
    logic [COL_W-1:0] col;
    logic             keep;
    logic             acc_en;
    logic             group_first;
    logic             emit;
    logic             done_evt;
    logic [YA_W-1:0]  ya_n;
    logic             c_hit;
    logic [CA_W-1:0]  ca_n;
    q_t               yq;
    cpair_t           cp_n;

    assign factor = decim_factor(size_q);
    assign cp_n   = '{cr: quantise(pix_cr), cb: quantise(pix_cb)};

    always_ff @(posedge clk) begin
        if (rst) size_q <= SZ_NINTH;
        else if (field_start) size_q <= pip_size_e'(size_sel);
    end

    pip_hcount #(.NCOL(NCOL)) u_hcount (
        .clk       (clk),
        .rst       (rst),
        .clr       (line_start || field_start),
        .pix_valid (pix_valid),
        .factor    (factor),
        .col       (col),
        .keep      (keep)
    );

    pip_linectl #(.NCOL(NCOL), .NL9(NL9), .NL16(NL16), .CDIV(CDIV)) u_linectl (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .line_start  (line_start),
        .size        (size_q),
        .keep        (keep),
        .col         (col),
        .acc_en      (acc_en),
        .group_first (group_first),
        .emit        (emit),
        .done_evt    (done_evt),
        .y_addr      (ya_n),
        .c_hit       (c_hit),
        .c_addr      (ca_n)
    );

    pip_vfilter #(.NCOL(NCOL)) u_vfilter (
        .clk    (clk),
        .rst    (rst),
        .acc_en (acc_en),
        .first  (group_first),
        .col    (col),
        .pix    (pix_y),
        .factor (factor),
        .yq     (yq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_we       <= 1'b0;
            c_we       <= 1'b0;
            field_done <= 1'b0;
            y_addr     <= '0;
            y_data     <= '0;
            c_addr     <= '0;
            c_data     <= '0;
        end else begin
            y_we       <= emit && !freeze;
            c_we       <= emit && c_hit && !freeze;
            field_done <= done_evt;
            if (emit) begin
                y_addr <= ya_n;
                y_data <= yq;
            end
            if (emit && c_hit) begin
                c_addr <= ca_n;
                c_data <= cp_n;
            end
        end
    end

    assert_freeze_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        $past(freeze) |-> (!y_we && !c_we));
    assert_chroma_pairing_R6: assert property (@(posedge clk) disable iff (rst)
        c_we |-> (y_we && int'(c_addr) * CDIV == int'(y_addr)));
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (rst)
        y_we |-> int'(y_addr) < NCOL * LN_MAX);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        field_done |=> !field_done);
    assert_done_row_end_R9: assert property (@(posedge clk) disable iff (rst)
        (field_done && y_we) |-> int'(y_addr) % NCOL == NCOL - 1);
endmodule

// File: tb/sim_pip_decim_writer.sv
module sim_pip_decim_writer;
    import pip_dec_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCOL   = 13;
    localparam int NL9    = 5;
    localparam int NL16   = 4;
    localparam int CDIV   = 6;
    localparam int LN_MAX = (NL9 > NL16) ? NL9 : NL16;
    localparam int YA_W   = $clog2(NCOL * LN_MAX);
    localparam int CA_W   = $clog2((NCOL * LN_MAX + CDIV - 1) / CDIV);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic field_start = 1'b0, line_start = 1'b0, pix_valid = 1'b0;
    logic [7:0] pix_y = '0, pix_cb = '0, pix_cr = '0;
    logic size_sel = 1'b0, freeze = 1'b0;
    logic y_we, c_we, field_done;
    logic [YA_W-1:0] y_addr;
    logic [Q_W-1:0] y_data;
    logic [CA_W-1:0] c_addr;
    logic [2*Q_W-1:0] c_data;

    int checks = 0, errors = 0;
    int cur_field = 0, cur_sz = 0;
    int ny = 0, nc = 0, nd = 0, next_y = 0;
    bit mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pip_decim_writer #(.NCOL(NCOL), .NL9(NL9), .NL16(NL16), .CDIV(CDIV)) u0 (
        .clk(clk), .rst(rst), .field_start(field_start), .line_start(line_start),
        .pix_valid(pix_valid), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
        .size_sel(size_sel), .freeze(freeze), .y_we(y_we), .y_addr(y_addr),
        .y_data(y_data), .c_we(c_we), .c_addr(c_addr), .c_data(c_data),
        .field_done(field_done)
    );

    function automatic int py(int f, int ln, int x);
        return (f*37 + ln*29 + x*11 + ((ln*x) % 7)*13) % 256;
    endfunction
    function automatic int pcb(int f, int ln, int x);
        return (f*5 + ln*3 + x*7 + 40) % 256;
    endfunction
    function automatic int pcr(int f, int ln, int x);
        return (1000 - ln*9 - x*5 + f*3) % 256;
    endfunction
    function automatic int qm(int v);
        return ((v + 2) / 4 > 63) ? 63 : (v + 2) / 4;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mon_en) begin
            int f, nl, ln, c, s, e;
            f  = cur_sz ? 4 : 3;
            nl = cur_sz ? NL16 : NL9;
            if (y_we) begin
                ln = int'(y_addr) / NCOL;
                c  = int'(y_addr) % NCOL;
                s  = 0;
                for (int k = 0; k < f; k++) s += py(cur_field, f*ln + k, f*c);
                e = qm((s + f/2) / f);
                chk(int'(y_addr) == next_y, "R5 R10 luma address order", int'(y_addr), next_y);
                chk(int'(y_data) == e, "R3 R4 luma value", int'(y_data), e);
                next_y++;
                ny++;
                if (c_we) begin
                    e = qm(pcr(cur_field, f*ln + f - 1, f*c)) * 64
                      + qm(pcb(cur_field, f*ln + f - 1, f*c));
                    chk(int'(c_data) == e, "R6 chroma pair value", int'(c_data), e);
                end
            end
            if (c_we) begin
                chk(y_we && int'(y_addr) % CDIV == 0 && int'(c_addr) == int'(y_addr) / CDIV,
                    "R6 chroma address", int'(c_addr), int'(y_addr) / CDIV);
                nc++;
            end
            if (field_done) begin
                nd++;
                if (y_we) chk(int'(y_addr) == NCOL*nl - 1, "R9 done with last write",
                              int'(y_addr), NCOL*nl - 1);
            end
        end
    end

    task automatic run_field(int sz, int m, int frz_line, bit gaps, bit flip);
        int f, nl, grp, exp_ny;
        @(posedge clk);
        cur_field++;
        cur_sz = sz;
        ny = 0; nc = 0; nd = 0; next_y = 0;
        @(negedge clk);
        field_start = 1'b1;
        size_sel = sz[0];
        @(negedge clk);
        field_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pix_valid = 1'b1;
            pix_y = 8'(i*50 + 7); pix_cb = 8'(i*9); pix_cr = 8'(200 - i);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        f  = sz ? 4 : 3;
        nl = sz ? NL16 : NL9;
        for (int ln = 0; ln < m; ln++) begin
            if (ln == frz_line) freeze = 1'b1;
            if (flip && ln == 1) size_sel = ~sz[0];
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            for (int x = 0; x < NCOL*f + 2; x++) begin
                if (gaps && x % 4 == 3) begin
                    pix_valid = 1'b0;
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                pix_y  = 8'(py(cur_field, ln, x));
                pix_cb = 8'(pcb(cur_field, ln, x));
                pix_cr = 8'(pcr(cur_field, ln, x));
                @(negedge clk);
            end
            pix_valid = 1'b0;
            repeat (2) @(negedge clk);
        end
        freeze = 1'b0;
        repeat (4) @(negedge clk);
        grp = m / f;
        if (grp > nl) grp = nl;
        if (frz_line / f < grp) grp = frz_line / f;
        exp_ny = grp * NCOL;
        chk(ny == exp_ny, "R2 R5 R7 R8 luma write count", ny, exp_ny);
        chk(nc == (exp_ny + CDIV - 1) / CDIV, "R6 chroma write count", nc,
            (exp_ny + CDIV - 1) / CDIV);
        chk(nd == ((m / f >= nl) ? 1 : 0), "R9 done pulse count", nd,
            (m / f >= nl) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!y_we && !c_we && !field_done, "R1 reset outputs",
            int'({y_we, c_we, field_done}), 0);
        mon_en = 1'b1;
        run_field(0, 3*NL9 + 1, 999, 1'b0, 1'b0);  // R7 extra line
        run_field(1, 4*NL16 + 1, 999, 1'b1, 1'b0); // gapped pixels
        run_field(0, 3*NL9 + 1, 0, 1'b0, 1'b0);    // R8 fully frozen
        run_field(0, 3*NL9 + 1, 7, 1'b0, 1'b0);    // R8 freeze from line 7
        run_field(1, 9, 999, 1'b0, 1'b1);          // R2 flip, R10 aborted field
        run_field(0, 3*NL9, 999, 1'b1, 1'b1);      // R2 flip, R10 restart
        run_field(1, 4*NL16, 999, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule